// File: doc/BRIEF.md
# Edge-Counting Frequency Direction Comparator

This block tells a frequency-tracking loop which way to steer its synthesizer. It watches two square waves: the hard-limited output of the synthesizer and an unknown signal to be measured. Both are asynchronous to the system clock, so each passes through a synchronizer and a rising-edge detector first. It then produces a single direction bit, plus a one-cycle strobe whenever that bit flips. The loop's up/down counter uses the direction bit as its count direction.

The decision rests on a simple rule. Within one period of the slower wave, the faster wave shows at least two rising edges. One saturating edge counter counts unknown-signal edges and is cleared by every synthesizer edge. A second counter counts synthesizer edges and is cleared by every unknown-signal edge. When either counter reaches its second edge, it drives a set/reset latch. No equality state exists: with matched frequencies the latch gets no decision of its own, and the closed loop makes the bit alternate. The decision may be wrong during an initial settling interval. It is valid once two edges of the faster wave have fallen inside one period of the slower one.

Top module: `fcmp_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dir_o` is 0 and `dir_strobe_o` is 0 until an edge decision occurs; asserting `rst_n` low clears `dir_o` without waiting for a clock edge.
- R2: A rising edge on a raw input, driven between clock edges, can change `dir_o` at the third rising clock edge after it is driven, not earlier (two synchronizer stages, then the latch).
- R3: Two rising edges of `unknown_i` with no rising edge of `synth_i` between them set `dir_o` to 1 (request a higher synthesizer frequency).
- R4: Two rising edges of `synth_i` with no rising edge of `unknown_i` between them set `dir_o` to 0 (request a lower synthesizer frequency).
- R5: A counter is cleared only after the clearing edge has been evaluated. An edge of the counted signal that coincides with the clearing edge still completes a pair. That same edge is also kept as the first edge of the new count.
- R6: When the set and reset decisions fall in the same clock cycle, `dir_o` keeps its previous value and no strobe is produced.
- R7: `dir_strobe_o` is high for exactly the cycles in which `dir_o` has just taken a new value, and low otherwise.
- R8: With equal periods and both counters primed, the comparator produces no decision of its own: `dir_o` stays at the value it held and no strobe occurs.
- R9: When the unknown signal is faster, `dir_o` settles to 1. When the synthesizer is faster, `dir_o` settles to 0. Either way it then stays put while the edges keep coming, because the counters saturate at two and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| synth_i | input | 1 | Raw hard-limited synthesizer square wave, asynchronous |
| unknown_i | input | 1 | Raw unknown square wave, asynchronous |
| dir_o | output | 1 | 1 = raise synthesizer frequency, 0 = lower it |
| dir_strobe_o | output | 1 | One-cycle pulse when `dir_o` changes |

## Verification
The set decision and the reset decision can land in the same clock cycle. This happens when both inputs rise in the same cycle while each counter already holds one edge. The bench provokes it by driving both raw inputs with identical pulse trains from a known state of `dir_o`, starting once from 0 and once from 1. It judges the result at the ports: `dir_o` must keep its prior value and the strobe must stay quiet. The equal-period cases of the period sweep lean on the same collision, because their edges always coincide.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // channel indices for the per-input front ends
  localparam int unsigned CH_SYNTH   = 0;
  localparam int unsigned CH_UNKNOWN = 1;
  localparam int unsigned NUM_CH     = 2;

  // steering request carried by the latch
  typedef enum logic {
    STEER_DOWN = 1'b0,
    STEER_UP   = 1'b1
  } steer_e;

endpackage

// File: rtl/fcmp_rst_sync.sv
module fcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/fcmp_sync_edge.sv
module fcmp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], raw_i};
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = level & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fcmp_edge_counter.sv
module fcmp_edge_counter #(
  parameter int unsigned LIMIT = 2,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic own_rise_i,
  input  logic other_rise_i,
  output logic hit_o
);

  localparam logic [CW-1:0] TOP     = CW'(LIMIT);
  localparam logic [CW-1:0] PRE_TOP = CW'(LIMIT - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_pre;

  // evaluate with the count held before any clear of this cycle
  assign at_pre = (cnt_q >= PRE_TOP);
  assign hit_o  = own_rise_i & at_pre;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (other_rise_i) begin
      cnt_en = 1'b1;
      cnt_d  = own_rise_i ? ONE : '0;
    end else if (own_rise_i && (cnt_q != TOP)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (other_rise_i && !own_rise_i) |=> (cnt_q == '0));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (other_rise_i && own_rise_i) |=> (cnt_q == ONE));

endmodule

// File: rtl/fcmp_dir_latch.sv
module fcmp_dir_latch
  import fcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dir_o,
  output logic strobe_o
);

  steer_e dir_q;
  steer_e dir_d;
  logic   dir_en;
  logic   strobe_q;
  logic   strobe_d;

  // a colliding set and clear leaves the latch alone
  always_comb begin
    dir_en   = set_i ^ clr_i;
    dir_d    = set_i ? STEER_UP : STEER_DOWN;
    strobe_d = dir_en && (dir_d != dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= STEER_DOWN;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  assign dir_o    = (dir_q == STEER_UP);
  assign strobe_o = strobe_q;

  // R3
  set_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> dir_o);

  // R4
  clr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !dir_o);

  // R6
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> ($stable(dir_o) && !strobe_o));

endmodule

// File: rtl/fcmp_top.sv
module fcmp_top
  import fcmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EDGE_LIMIT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic synth_i,
  input  logic unknown_i,
  output logic dir_o,
  output logic dir_strobe_o
);

  logic              rst_ns;
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] rise;
  logic              up_hit;
  logic              down_hit;

  assign raw[CH_SYNTH]   = synth_i;
  assign raw[CH_UNKNOWN] = unknown_i;

  fcmp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_ns)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_front
    fcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_ns),
      .raw_i  (raw[ch]),
      .rise_o (rise[ch])
    );
  end

  // unknown edges inside one synthesizer period -> steer up
  fcmp_edge_counter #(.LIMIT(EDGE_LIMIT)) u_up_cnt (
    .clk          (clk),
    .rst_n        (rst_ns),
    .own_rise_i   (rise[CH_UNKNOWN]),
    .other_rise_i (rise[CH_SYNTH]),
    .hit_o        (up_hit)
  );

  // synthesizer edges inside one unknown period -> steer down
  fcmp_edge_counter #(.LIMIT(EDGE_LIMIT)) u_down_cnt (
    .clk          (clk),
    .rst_n        (rst_ns),
    .own_rise_i   (rise[CH_SYNTH]),
    .other_rise_i (rise[CH_UNKNOWN]),
    .hit_o        (down_hit)
  );

  fcmp_dir_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_ns),
    .set_i    (up_hit),
    .clr_i    (down_hit),
    .dir_o    (dir_o),
    .strobe_o (dir_strobe_o)
  );

  // R7
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (dir_o != $past(dir_o)) |-> dir_strobe_o);

  // R7
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (dir_o == $past(dir_o)) |-> !dir_strobe_o);

  // R2
  no_early_edge_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(rise[CH_SYNTH] || rise[CH_UNKNOWN]) |=> !dir_strobe_o);

endmodule

// File: tb/fcmp_top_test.sv
module fcmp_top_test;

  logic clk;
  logic rst_n;
  logic man_u, man_s;
  logic gen_en;
  int   per_u, per_s;
  int   cu, cs;
  logic gen_u, gen_s;
  logic synth_raw, unknown_raw;
  logic dir, strobe;

  int n_chk;
  int n_err;
  int strobe_cnt;
  logic mon_en;
  logic dir_prev;

  fcmp_top uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .synth_i      (synth_raw),
    .unknown_i    (unknown_raw),
    .dir_o        (dir),
    .dir_strobe_o (strobe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign gen_u       = (cu < per_u / 2);
  assign gen_s       = (cs < per_s / 2);
  assign unknown_raw = gen_en ? gen_u : man_u;
  assign synth_raw   = gen_en ? gen_s : man_s;

  always @(negedge clk) begin
    if (!gen_en) begin
      cu <= 0;
      cs <= 0;
    end else begin
      cu <= (cu == per_u - 1) ? 0 : cu + 1;
      cs <= (cs == per_s - 1) ? 0 : cs + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7 monitor: strobe marks exactly the cycles where dir has just changed
  always @(negedge clk) begin
    if (mon_en) begin
      chk(strobe == (dir != dir_prev), "R7 strobe vs change", int'(strobe), int'(dir != dir_prev));
    end
    if (strobe) strobe_cnt++;
    dir_prev <= dir;
  end

  task automatic pulse(input bit u, input bit s);
    @(negedge clk);
    man_u = u;
    man_s = s;
    repeat (2) @(negedge clk);
    man_u = 1'b0;
    man_s = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int s0;
    int hold_v;
    int mx;
    n_chk = 0; n_err = 0; strobe_cnt = 0;
    mon_en = 1'b0; dir_prev = 1'b0;
    man_u = 1'b0; man_s = 1'b0; gen_en = 1'b0;
    per_u = 4; per_s = 4;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(dir == 1'b0, "R1 dir in reset", int'(dir), 0);
    chk(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dir == 1'b0, "R1 dir after release", int'(dir), 0);
    chk(strobe == 1'b0, "R1 strobe after release", int'(strobe), 0);
    mon_en = 1'b1;

    // R2 latency, R3 set: first unknown edge primes the counter
    pulse(1'b1, 1'b0);
    @(negedge clk);
    man_u = 1'b1;
    @(negedge clk);
    chk(dir == 1'b0, "R2 no change after 1 edge", int'(dir), 0);
    @(negedge clk);
    chk(dir == 1'b0, "R2 no change after 2 edges", int'(dir), 0);
    @(negedge clk);
    chk(dir == 1'b1, "R2 change at third edge", int'(dir), 1);
    chk(strobe == 1'b1, "R7 strobe with change", int'(strobe), 1);
    @(negedge clk);
    chk(strobe == 1'b0, "R7 strobe one cycle", int'(strobe), 0);
    man_u = 1'b0;
    repeat (3) @(negedge clk);
    chk(dir == 1'b1, "R3 two unknown edges steer up", int'(dir), 1);

    // R4: two synthesizer edges steer down
    s0 = strobe_cnt;
    pulse(1'b0, 1'b1);
    chk(dir == 1'b1, "R4 one synth edge no decision", int'(dir), 1);
    pulse(1'b0, 1'b1);
    chk(dir == 1'b0, "R4 two synth edges steer down", int'(dir), 0);
    chk(strobe_cnt - s0 == 1, "R7 one strobe for R4", strobe_cnt - s0, 1);

    // R5: coincident clearing edge still completes the pair
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    chk(dir == 1'b1, "R5 edge evaluated before clear", int'(dir), 1);
    pulse(1'b0, 1'b1);
    chk(dir == 1'b0, "R5 coincident edge kept as first", int'(dir), 0);

    // R6: collisions from dir=0
    s0 = strobe_cnt;
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    chk(dir == 1'b0, "R6 collision holds 0", int'(dir), 0);
    chk(strobe_cnt == s0, "R6 no strobe from 0", strobe_cnt - s0, 0);
    pulse(1'b1, 1'b0);
    chk(dir == 1'b1, "R3 saturated counter sets", int'(dir), 1);
    s0 = strobe_cnt;
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    chk(dir == 1'b1, "R6 collision holds 1", int'(dir), 1);
    chk(strobe_cnt == s0, "R6 no strobe from 1", strobe_cnt - s0, 0);

    // R8 / R9: sweep of period pairs
    for (int pu = 4; pu <= 11; pu++) begin
      for (int ps = 4; ps <= 11; ps++) begin
        gen_en = 1'b0;
        repeat (8) @(negedge clk);
        pulse(1'b1, 1'b1);
        repeat (2) @(negedge clk);
        hold_v = int'(dir);
        mx = (pu > ps) ? pu : ps;
        per_u = pu;
        per_s = ps;
        s0 = strobe_cnt;
        gen_en = 1'b1;
        repeat (24 * mx) @(negedge clk);
        if (pu == ps) begin
          chk(int'(dir) == hold_v, "R8 equal periods hold", int'(dir), hold_v);
          chk(strobe_cnt == s0, "R8 equal periods no strobe", strobe_cnt - s0, 0);
        end else begin
          chk(int'(dir) == int'(pu < ps), "R9 settled direction", int'(dir), int'(pu < ps));
        end
        s0 = strobe_cnt;
        repeat (4 * mx) @(negedge clk);
        chk(int'(dir) == ((pu == ps) ? hold_v : int'(pu < ps)), "R9 stays settled",
            int'(dir), (pu == ps) ? hold_v : int'(pu < ps));
        chk(strobe_cnt == s0, "R9 no strobe once settled", strobe_cnt - s0, 0);
      end
    end
    gen_en = 1'b0;
    repeat (8) @(negedge clk);

    // R1: asynchronous reset clears a set direction
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk(dir == 1'b1, "R3 set before reset", int'(dir), 1);
    mon_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(dir == 1'b0, "R1 async clear", int'(dir), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dir == 1'b0 && strobe == 1'b0, "R1 quiet after re-release", int'(dir), 0);

    finish_run();
  end

endmodule